// File: doc/BRIEF.md
# Programmable Logic Cluster with Windowed Local Routing

This block is a small programmable logic cluster. It holds a parameterised number of logic elements. Each element is a look-up table of `LUT_K` inputs, a D register that captures the table output, and a two-way output selector. The selector presents either the table output or the register output. The table inputs are not fed by a full crossbar. Each one is fed by a narrow window mux that sees only a contiguous slice of an ordered signal list. That list holds the cluster inputs followed by the register outputs of all elements. Because any logic function can be rewritten by reprogramming its table, the narrow windows keep every cluster input and every feedback logically interchangeable. Each table input costs far fewer mux legs.

All programming state sits in one serial chain: truth tables, window selects and output-select bits. The chain is loaded one bit per clock while `cfg_en` is high. During loading, every register is held at zero and every element output is forced low. Once `cfg_en` drops, the cluster behaves as the programmed logic. A combinational output follows its inputs in the same cycle, and a registered output shows the table value captured at the previous clock edge.

Top module: `lutc_cluster`

## Requirements
- R1: While `cfg_en` is high, each rising clock edge shifts the chain one place toward its most significant end and loads `cfg_din` into bit 0. After the whole chain length has been shifted, the first bit sent sits in the most significant bit.
- R2: Chain layout. Element e owns bits [e*EB +: EB], where EB = 2^K + K*SW + 1. Within that slice, bits [2^K-1:0] are the truth table. The select for table input j occupies bits [2^K + j*SW +: SW]. The top bit is the output select. SW = ceil(log2(W)) and W = NUM_IN + NUM_ELEM - K + 1.
- R3: The table output equals truth-table bit number A. A is the address formed with table input j as address bit j.
- R4: The routing list has L = NUM_IN + NUM_ELEM positions. Position p < NUM_IN is cluster input p. Position NUM_IN + e is the register output of element e, not its selected output.
- R5: For an even-numbered element, table input j with select code s < W takes list position j + s.
- R6: For an odd-numbered element, table input j with select code s < W takes list position (j + s + L/2) mod L. With the default sizes, this brings every list signal to a fanout of exactly 5 table inputs.
- R7: A select code s >= W drives its table input to logic 0.
- R8: While `cfg_en` is high, every element output is 0 and every register is cleared to 0 at each clock edge.
- R9: With output select 0, the element output is the table output in the same cycle. With output select 1, the element output is the register, which holds the table output captured at the previous rising edge.
- R10: Synchronous `rst` clears the whole chain and every register, so all element outputs read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Programming enable; shifts the chain and holds the logic quiet |
| cfg_din | input | 1 | Serial programming data |
| clu_in | input | NUM_IN | Cluster input signals |
| elem_out | output | NUM_ELEM | One output per logic element |

## Verification
The hardest behaviour to observe from the ports is which list position each window mux actually routes. This matters most for the rotated odd elements, for out-of-window select codes, and for the feedback positions, since none of them is visible directly. The stimulus programs single-bit truth tables that copy one chosen table input to the output. It then sweeps that input's select through every code, both in-window and beyond the window, while the cluster inputs change randomly every cycle. Each element output therefore exposes exactly one routed signal. Registered mode with random tables and selects reaching the feedback positions then exercises the one-cycle loop through the registers.

// File: rtl/lutc_pkg.sv
package lutc_pkg;

    // Select field width for a window of the given size.
    function automatic int sel_width(input int win);
        return (win > 1) ? $clog2(win) : 1;
    endfunction

    // Map a window position to a routing list index. Odd elements see the
    // list rotated by half its length, which evens out per-signal fanout.
    function automatic int list_pos(input int elem, input int pos, input int nsig);
        return (pos + (elem % 2) * (nsig / 2)) % nsig;
    endfunction

endpackage

// File: rtl/lutc_cfg_chain.sv
module lutc_cfg_chain #(
    parameter int WIDTH = 58
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             shift_in,
    output logic [WIDTH-1:0] cfg_bits
);

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.bits = '0;
        end else if (shift_en) begin
            st_d.bits = {st_q.bits[WIDTH-2:0], shift_in};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cfg_bits = st_q.bits;

    // R1: a new bit enters at the bottom and the rest move up by one
    p_shift_in_r1: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> cfg_bits[0] == $past(shift_in));
    p_shift_move_r1: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> cfg_bits[WIDTH-1:1] == $past(cfg_bits[WIDTH-2:0]));
    // R1: with shifting off, the chain keeps its contents
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(cfg_bits));

endmodule

// File: rtl/lutc_win_mux.sv
module lutc_win_mux #(
    parameter  int NSIG = 8,
    parameter  int WIN  = 5,
    parameter  int ELEM = 0,
    parameter  int POS  = 0,
    localparam int SW   = lutc_pkg::sel_width(WIN)
) (
    input  logic [NSIG-1:0] sig,
    input  logic [SW-1:0]   sel,
    output logic            y
);

    logic [WIN-1:0] win;
    logic           unused_sig;

    // Each leg of the window is a fixed wire chosen at elaboration time.
    for (genvar s = 0; s < WIN; s++) begin : g_leg
        assign win[s] = sig[lutc_pkg::list_pos(ELEM, POS + s, NSIG)];
    end

    // Legs outside the window are simply not wired.
    assign unused_sig = ^sig;

    // Codes past the last leg fall through to 0.
    always_comb begin
        y = 1'b0;
        for (int s = 0; s < WIN; s++) begin
            if (int'(sel) == s) begin
                y = win[s];
            end
        end
    end

endmodule

// File: rtl/lutc_ble.sv
module lutc_ble #(
    parameter  int K    = 4,
    parameter  int NSIG = 8,
    parameter  int WIN  = 5,
    parameter  int ELEM = 0,
    localparam int SW   = lutc_pkg::sel_width(WIN),
    localparam int TW   = 1 << K,
    localparam int EB   = TW + K * SW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_en,
    input  logic [NSIG-1:0] sig,
    input  logic [EB-1:0]   cfg,
    output logic            elem_y,
    output logic            reg_q
);

    localparam int SEL_LO   = TW;
    localparam int OSEL_BIT = EB - 1;

    typedef struct packed {
        logic ff;
    } elem_st_t;

    elem_st_t       st_d, st_q;
    logic [TW-1:0]  truth;
    logic [K-1:0]   tbl_in;
    logic           lut_y;
    logic           osel;

    assign truth = cfg[TW-1:0];
    assign osel  = cfg[OSEL_BIT];

    for (genvar j = 0; j < K; j++) begin : g_in
        lutc_win_mux #(
            .NSIG (NSIG),
            .WIN  (WIN),
            .ELEM (ELEM),
            .POS  (j)
        ) u_mux (
            .sig (sig),
            .sel (cfg[SEL_LO + j*SW +: SW]),
            .y   (tbl_in[j])
        );
    end

    // The table inputs act as the select lines of a 2^K:1 mux over the truth bits.
    assign lut_y = truth[tbl_in];

    always_comb begin
        st_d = st_q;
        if (rst || cfg_en) begin
            st_d.ff = 1'b0;
        end else begin
            st_d.ff = lut_y;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign reg_q  = st_q.ff;
    assign elem_y = cfg_en ? 1'b0 : (osel ? st_q.ff : lut_y);

    // R8: programming clears the register
    p_reg_clear_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> reg_q == 1'b0);
    // R9: the registered path shows last cycle's table value
    p_reg_latency_r9: assert property (@(posedge clk) disable iff (rst)
        (osel && !cfg_en && $past(!cfg_en && !rst)) |-> elem_y == $past(lut_y));
    // R5/R6: a zero select on the first table input reaches the window base
    p_win_base_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg[SEL_LO +: SW] == '0) |-> tbl_in[0] == sig[lutc_pkg::list_pos(ELEM, 0, NSIG)]);

endmodule

// File: rtl/lutc_cluster.sv
module lutc_cluster #(
    parameter int NUM_IN   = 6,
    parameter int NUM_ELEM = 2,
    parameter int LUT_K    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_en,
    input  logic                cfg_din,
    input  logic [NUM_IN-1:0]   clu_in,
    output logic [NUM_ELEM-1:0] elem_out
);

    localparam int NSIG = NUM_IN + NUM_ELEM;
    localparam int WIN  = NSIG - LUT_K + 1;
    localparam int SW   = lutc_pkg::sel_width(WIN);
    localparam int EB   = (1 << LUT_K) + LUT_K * SW + 1;
    localparam int TOT  = NUM_ELEM * EB;

    logic [TOT-1:0]      cfg_all;
    logic [NUM_ELEM-1:0] fb_q;
    logic [NSIG-1:0]     sig;

    // Routing list: cluster inputs first, then the element registers.
    assign sig = {fb_q, clu_in};

    lutc_cfg_chain #(
        .WIDTH (TOT)
    ) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .shift_in (cfg_din),
        .cfg_bits (cfg_all)
    );

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_ble
        lutc_ble #(
            .K    (LUT_K),
            .NSIG (NSIG),
            .WIN  (WIN),
            .ELEM (e)
        ) u_ble (
            .clk    (clk),
            .rst    (rst),
            .cfg_en (cfg_en),
            .sig    (sig),
            .cfg    (cfg_all[e*EB +: EB]),
            .elem_y (elem_out[e]),
            .reg_q  (fb_q[e])
        );
    end

    // R8: outputs stay quiet throughout programming
    p_out_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> elem_out == '0);
    // R10: the cycle after reset, the cleared chain gives all-zero outputs
    p_reset_zero_r10: assert property (@(posedge clk)
        $past(rst) && rst |-> elem_out == '0);

endmodule

// File: tb/tb_lutc_cluster.sv
`timescale 1ns/1ps
module tb_lutc_cluster;

    localparam int I   = 6;
    localparam int N   = 2;
    localparam int K   = 4;
    localparam int L   = I + N;
    localparam int W   = L - K + 1;
    localparam int SW  = 3;
    localparam int T   = 1 << K;
    localparam int EB  = T + K * SW + 1;
    localparam int TOT = N * EB;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_en = 1'b0;
    logic         cfg_din = 1'b0;
    logic [I-1:0] clu_in = '0;
    logic [N-1:0] elem_out;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    bit [T-1:0] m_truth [N];
    int         m_sel   [N][K];
    bit         m_osel  [N];
    bit         m_ff    [N];

    lutc_cluster #(.NUM_IN(I), .NUM_ELEM(N), .LUT_K(K)) dut (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .clu_in   (clu_in),
        .elem_out (elem_out)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: %s got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // R4, R5, R6, R7: value reaching table input j of element e
    function automatic bit route(input int e, input int j, input logic [I-1:0] iv);
        int s;
        int idx;
        s = m_sel[e][j];
        if (s >= W) return 1'b0;
        idx = (j + s + (e % 2) * (L / 2)) % L;
        if (idx < I) return iv[idx];
        return m_ff[idx - I];
    endfunction

    // R3: table lookup
    function automatic bit model_lut(input int e, input logic [I-1:0] iv);
        int addr;
        addr = 0;
        for (int j = 0; j < K; j++) begin
            if (route(e, j, iv)) addr = addr | (1 << j);
        end
        return m_truth[e][addr];
    endfunction

    // R1, R2: assemble the chain image and shift it in, top bit first
    task automatic load_cfg();
        bit [TOT-1:0] vec;
        vec = '0;
        for (int e = 0; e < N; e++) begin
            vec[e*EB +: T] = m_truth[e];
            for (int j = 0; j < K; j++) begin
                vec[e*EB + T + j*SW +: SW] = SW'(m_sel[e][j]);
            end
            vec[e*EB + EB - 1] = m_osel[e];
        end
        for (int b = TOT - 1; b >= 0; b--) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_din = vec[b];
            clu_in  = I'($urandom);
            #1;
            check("R8", "output while programming", int'(elem_out), 0);
            @(posedge clk);
        end
        @(negedge clk);
        cfg_en = 1'b0;
        for (int e = 0; e < N; e++) m_ff[e] = 1'b0;
    endtask

    // Called at a falling edge; compares every element output each cycle.
    task automatic run_cycles(input int n, input string tag);
        for (int c = 0; c < n; c++) begin
            logic [I-1:0] iv;
            bit lv [N];
            iv = I'($urandom);
            clu_in = iv;
            #1;
            for (int e = 0; e < N; e++) begin
                lv[e] = model_lut(e, iv);
                check(tag, $sformatf("element %0d output", e), int'(elem_out[e]),
                      int'(m_osel[e] ? m_ff[e] : lv[e]));
            end
            @(posedge clk);
            for (int e = 0; e < N; e++) m_ff[e] = lv[e];
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cfg_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R10", "outputs in reset", int'(elem_out), 0);
        rst = 1'b0;
        for (int e = 0; e < N; e++) begin
            m_truth[e] = '0;
            m_osel[e]  = 1'b0;
            m_ff[e]    = 1'b0;
            for (int j = 0; j < K; j++) m_sel[e][j] = 0;
        end
        @(negedge clk);
        run_cycles(4, "R10");
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        do_reset();

        // Window sweep: a single-bit table copies table input j to the output
        for (int j = 0; j < K; j++) begin
            for (int s = 0; s < (1 << SW); s++) begin
                for (int e = 0; e < N; e++) begin
                    for (int a = 0; a < T; a++) m_truth[e][a] = bit'((a >> j) & 1);
                    for (int q = 0; q < K; q++) m_sel[e][q] = int'($urandom % (1 << SW));
                    m_sel[e][j] = s;
                    m_osel[e]   = 1'b0;
                end
                load_cfg();
                if (s >= W) run_cycles(6, "R7");
                else        run_cycles(6, "R1,R2,R5,R6");
            end
        end

        // Random tables, in-window selects, combinational outputs
        for (int r = 0; r < 6; r++) begin
            for (int e = 0; e < N; e++) begin
                m_truth[e] = T'($urandom);
                for (int q = 0; q < K; q++) m_sel[e][q] = int'($urandom % W);
                m_osel[e] = 1'b0;
            end
            load_cfg();
            run_cycles(20, "R3");
        end

        // Registered outputs with feedback reachable through the windows
        for (int r = 0; r < 6; r++) begin
            for (int e = 0; e < N; e++) begin
                m_truth[e] = T'($urandom);
                for (int q = 0; q < K; q++) m_sel[e][q] = int'($urandom % W);
                m_sel[e][K-1] = W - 1;
                m_osel[e] = bit'(r % 2 == 0 || e == 0);
            end
            load_cfg();
            run_cycles(30, "R4,R9");
        end

        // Reset in the middle of operation clears chain and registers
        do_reset();
        run_cycles(4, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule